// File: doc/BRIEF.md
# Line-Locked Accumulation Interval Controller

This block decides when each low-rate accumulation interval ends and measures the length of the line cycle. It watches a stream of signed phase-reference samples, qualified by a sample strobe, and detects rising zero crossings of that reference. After every accepted crossing a holdoff window, three quarters of the last measured cycle, blocks further detections so that noise and harmonics near the crossing cannot produce extra events.

With line lock disabled, every interval is exactly the programmed minimum count of samples long. With line lock enabled, an interval closes only at the first accepted rising crossing seen once the minimum count has passed, so each interval covers a whole number of line cycles; if the line is missing, a watchdog closes the interval at twice the minimum count and raises a no-line flag. For each finished interval the block emits a one-clock pulse and publishes the sample count of that interval as the divisor for the downstream accumulators. A typical setting is a minimum count of 2000 samples, roughly 0.79 s at 2521 samples per second.

Top module: `llk_ctrl`

## Requirements
- R1: A crossing candidate is a strobed sample whose sign bit is 0 (value >= 0) when the previous strobed sample had sign bit 1 (value < 0); a negative-going change never counts. The sample before the first one after reset is treated as non-negative.
- R2: After an accepted crossing, the next H strobed samples cannot be accepted as crossings. H is DEF_HOLD for the first crossing after reset and floor(3*C/4) otherwise, where C is the cycle length just measured by that crossing.
- R3: `period` is the number of strobed samples from one accepted crossing to the next (saturating at 2^PER_W-1), updated one clock after the accepting sample; it stays 0 until two crossings have been accepted and changes at no other time.
- R4: With `lock_en`=0, an interval ends on the strobed sample that brings its count to M, where M = `min_count`, or 1 when `min_count` is 0.
- R5: With `lock_en`=1, an interval ends on the first accepted crossing whose sample count within the interval is greater than M.
- R6: With `lock_en`=1 and no qualifying crossing, the interval ends on the sample whose count reaches 2*M and `no_line` becomes 1; every other interval end sets `no_line` to 0.
- R7: `interval_end` is high for the one clock after the sample that ends the interval; `divisor` (the interval's sample count) and `no_line` change only in that same clock.
- R8: While `rst_n` is low, `interval_end`, `divisor`, `period` and `no_line` are 0, and the interval, cycle and holdoff counts restart.
- R9: Clocks with `smp_valid`=0 change no state, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Strobe marking a new reference sample |
| smp_data | input | SAMPLE_W | Signed phase-reference sample |
| min_count | input | COUNT_W | Minimum interval length in samples (0 read as 1) |
| lock_en | input | 1 | Close intervals on line crossings |
| interval_end | output | 1 | One-clock pulse at the end of an interval |
| divisor | output | COUNT_W+1 | Sample count of the last finished interval |
| period | output | PER_W | Samples per line cycle, last measurement |
| no_line | output | 1 | Last interval was closed by the watchdog |

## Verification
The assertions assume `min_count` and `lock_en` stay constant across the clock in which an interval is closed, since the checker compares the divisor with the values sampled on the ending sample. The stimulus changes these two inputs only between segments, after a reset, so every interval is started and finished under one setting. Between strobes the data bus carries random values, and the reference wave carries random amplitude, random gaps and short negative glitches just after its rising edges, which exercise the holdoff without leaving the stated sign convention.

// File: rtl/llk_pkg.sv
// Shared types for the line-locked interval controller.
package llk_pkg;
    // Reason an interval was closed on the current sample.
    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_COUNT = 2'd1,
        END_CROSS = 2'd2,
        END_FORCE = 2'd3
    } end_cause_t;
endpackage

// File: rtl/llk_zero_cross.sv
// Rising zero-crossing detector with holdoff.
// Assumes: smp_sign is the sign bit of the sample qualified by smp_valid;
// hold_len is the holdoff to load on an accepted crossing.
module llk_zero_cross #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_sign,
    input  logic [PER_W-1:0] hold_len,
    output logic             accept
);
    logic             prev_neg;
    logic [PER_W-1:0] hold_cnt;
    logic             rising;

    // Candidate: negative previous sample, non-negative current sample.
    always_comb begin
        rising = smp_valid && prev_neg && !smp_sign;
        accept = rising && (hold_cnt == '0);
    end

    // Track the previous polarity and run the holdoff countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_neg <= 1'b0;
            hold_cnt <= '0;
        end else if (smp_valid) begin
            prev_neg <= smp_sign;
            if (accept)
                hold_cnt <= hold_len;
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/llk_period.sv
// Line cycle measurement and holdoff length.
// Assumes: accept marks a strobed sample that is an accepted crossing.
module llk_period #(
    parameter int PER_W    = 12,
    parameter int DEF_HOLD = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             accept,
    output logic [PER_W-1:0] hold_len,
    output logic [PER_W-1:0] period
);
    localparam logic [PER_W-1:0] CYC_MAX = '1;

    logic [PER_W-1:0] cyc_cnt;
    logic             have_ref;
    logic [PER_W+1:0] three_q;

    // Holdoff: default before a reference, else 3/4 of the cycle just closed.
    always_comb begin
        three_q  = {2'b00, cyc_cnt} * 3;
        hold_len = have_ref ? three_q[PER_W+1:2] : PER_W'(DEF_HOLD);
    end

    // Count samples since the last crossing and latch the cycle length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt  <= '0;
            have_ref <= 1'b0;
            period   <= '0;
        end else if (smp_valid) begin
            if (accept) begin
                if (have_ref)
                    period <= cyc_cnt;
                have_ref <= 1'b1;
                cyc_cnt  <= PER_W'(1);
            end else if (cyc_cnt != CYC_MAX) begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/llk_interval.sv
// Interval counter: decides the end of each accumulation interval.
// Assumes: min_count and lock_en are stable while an interval is closed.
module llk_interval
    import llk_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic               accept,
    input  logic               lock_en,
    input  logic [COUNT_W-1:0] min_count,
    output logic               interval_end,
    output logic [COUNT_W:0]   divisor,
    output logic               no_line
);
    logic [COUNT_W:0] int_cnt;
    logic [COUNT_W:0] n_now;
    logic [COUNT_W:0] eff_min;
    logic [COUNT_W:0] limit2;
    end_cause_t       cause;

    // Classify the current sample against the end conditions.
    always_comb begin
        n_now   = int_cnt + 1'b1;
        eff_min = (min_count == '0) ? (COUNT_W+1)'(1) : {1'b0, min_count};
        limit2  = eff_min << 1;
        cause   = END_NONE;
        if (smp_valid) begin
            if (!lock_en) begin
                if (n_now >= eff_min) cause = END_COUNT;
            end else if (accept && (n_now > eff_min)) begin
                cause = END_CROSS;
            end else if (n_now >= limit2) begin
                cause = END_FORCE;
            end
        end
    end

    // Advance the count, publish divisor and flag at each interval end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_cnt      <= '0;
            interval_end <= 1'b0;
            divisor      <= '0;
            no_line      <= 1'b0;
        end else begin
            interval_end <= (cause != END_NONE);
            if (cause != END_NONE) begin
                int_cnt <= '0;
                divisor <= n_now;
                no_line <= (cause == END_FORCE);
            end else if (smp_valid) begin
                int_cnt <= n_now;
            end
        end
    end
endmodule

// File: rtl/llk_ctrl.sv
// Line-locked accumulation interval controller, top level.
// Assumes: one sample per smp_valid strobe, two's complement smp_data.
module llk_ctrl #(
    parameter int SAMPLE_W = 16,
    parameter int COUNT_W  = 16,
    parameter int PER_W    = 12,
    parameter int DEF_HOLD = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [COUNT_W-1:0]  min_count,
    input  logic                lock_en,
    output logic                interval_end,
    output logic [COUNT_W:0]    divisor,
    output logic [PER_W-1:0]    period,
    output logic                no_line
);
    logic             zc_accept;
    logic [PER_W-1:0] hold_len;

    llk_zero_cross #(.PER_W(PER_W)) u_zc (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_sign(smp_data[SAMPLE_W-1]), .hold_len(hold_len),
        .accept(zc_accept)
    );

    llk_period #(.PER_W(PER_W), .DEF_HOLD(DEF_HOLD)) u_per (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .accept(zc_accept), .hold_len(hold_len), .period(period)
    );

    llk_interval #(.COUNT_W(COUNT_W)) u_int (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .accept(zc_accept), .lock_en(lock_en), .min_count(min_count),
        .interval_end(interval_end), .divisor(divisor), .no_line(no_line)
    );
endmodule

// File: rtl/llk_ctrl_chk.sv
// Assertion checker for llk_ctrl, attached by bind.
module llk_ctrl_chk #(
    parameter int COUNT_W = 16,
    parameter int PER_W   = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic [COUNT_W-1:0] min_count,
    input logic               lock_en,
    input logic               interval_end,
    input logic [COUNT_W:0]   divisor,
    input logic [PER_W-1:0]   period,
    input logic               no_line,
    input logic               accept
);
    logic             valid_q, lock_q, acc_q;
    logic [COUNT_W:0] emin_q;

    // Remember the inputs seen on the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            lock_q  <= 1'b0;
            acc_q   <= 1'b0;
            emin_q  <= (COUNT_W+1)'(1);
        end else begin
            valid_q <= smp_valid;
            lock_q  <= lock_en;
            acc_q   <= accept;
            emin_q  <= (min_count == '0) ? (COUNT_W+1)'(1) : {1'b0, min_count};
        end
    end

    a_r3_period_only_on_crossing: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q |-> $stable(period));
    a_r4_free_running_length: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end && !lock_q |-> divisor == emin_q);
    a_r5_locked_past_minimum: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end && lock_q && !no_line |-> divisor > emin_q);
    a_r6_forced_at_twice: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end && no_line |-> lock_q && divisor == (emin_q << 1));
    a_r7_end_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end |-> valid_q);
    a_r7_divisor_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !interval_end |-> $stable(divisor) && $stable(no_line));
endmodule

bind llk_ctrl llk_ctrl_chk #(.COUNT_W(COUNT_W), .PER_W(PER_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .min_count(min_count),
    .lock_en(lock_en), .interval_end(interval_end), .divisor(divisor),
    .period(period), .no_line(no_line), .accept(zc_accept)
);

// File: tb/llk_ctrl_tb.sv
// Self-checking bench for llk_ctrl with a sample-level reference model.
module llk_ctrl_tb;
    localparam int CLK_NS   = 10;
    localparam int SW       = 16;
    localparam int CW       = 16;
    localparam int PW       = 12;
    localparam int DEF_HOLD = 31;
    localparam int CYC_MAX  = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [CW-1:0] min_count = '0;
    logic          lock_en = 1'b0;
    logic          interval_end;
    logic [CW:0]   divisor;
    logic [PW-1:0] period;
    logic          no_line;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // Reference model state.
    bit m_prev_neg, m_have, m_noline;
    int m_hold, m_cyc, m_per, m_int, m_div;

    always #(CLK_NS/2) clk = ~clk;

    llk_ctrl #(.SAMPLE_W(SW), .COUNT_W(CW), .PER_W(PW), .DEF_HOLD(DEF_HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .min_count(min_count), .lock_en(lock_en), .interval_end(interval_end),
        .divisor(divisor), .period(period), .no_line(no_line)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_min(input int m);
        return (m == 0) ? 1 : m;
    endfunction

    task automatic model_reset();
        m_prev_neg = 0; m_have = 0; m_noline = 0;
        m_hold = 0; m_cyc = 0; m_per = 0; m_int = 0; m_div = 0;
    endtask

    // One clock: drive a sample, advance the model, compare after the edge.
    task automatic step(input bit v, input logic [SW-1:0] d);
        bit exp_end = 0;
        bit neg, acc;
        int n, em;
        smp_valid = v;
        smp_data  = d;
        if (v) begin
            neg = d[SW-1];
            acc = m_prev_neg && !neg && (m_hold == 0);     // R1, R2
            m_prev_neg = neg;
            if (!acc && m_hold != 0) m_hold--;
            em = eff_min(int'(min_count));
            n  = m_int + 1;
            if (!lock_en && n >= em) begin                 // R4
                exp_end = 1; m_noline = 0;
            end else if (lock_en && acc && n > em) begin   // R5
                exp_end = 1; m_noline = 0;
            end else if (lock_en && n >= 2*em) begin       // R6
                exp_end = 1; m_noline = 1;
            end
            if (exp_end) begin m_div = n; m_int = 0; end
            else m_int = n;
            if (acc) begin                                  // R2, R3
                m_hold = m_have ? (3*m_cyc)/4 : DEF_HOLD;
                if (m_have) m_per = m_cyc;
                m_have = 1;
                m_cyc = 1;
            end else if (m_cyc < CYC_MAX) begin
                m_cyc++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (v) check(interval_end == exp_end, "R7 interval_end", interval_end, exp_end);
        else   check(interval_end == 1'b0, "R9 idle interval_end", interval_end, 0);
        check(int'(divisor) == m_div, "R4/R5 divisor (R7)", int'(divisor), m_div);
        check(no_line == m_noline, "R6 no_line", no_line, m_noline);
        check(int'(period) == m_per, "R3 period", int'(period), m_per);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(interval_end == 0, "R8 reset interval_end", interval_end, 0);
        check(divisor == 0, "R8 reset divisor", int'(divisor), 0);
        check(period == 0, "R8 reset period", int'(period), 0);
        check(no_line == 0, "R8 reset no_line", no_line, 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Square-ish reference of period p with glitches and strobe gaps.
    task automatic run_wave(input int p, input int nsamp, input int glitch_pct,
                            input int gap_pct, input bit flat);
        int ph = 0;
        int amp;
        logic [SW-1:0] d;
        for (int k = 0; k < nsamp; k++) begin
            if (($urandom % 100) < gap_pct) begin
                step(1'b0, SW'($urandom));                   // R9
            end else begin
                amp = 1 + ($urandom % 2000);
                if (flat) d = SW'(amp);
                else if (ph < p/2) d = SW'(amp);
                else d = SW'(-amp);
                if (!flat && (ph == 2 || ph == 3) && ($urandom % 100) < glitch_pct)
                    d = SW'(-amp);                           // R2 glitch in holdoff
                if (!flat && ph == 1 && ($urandom % 100) < glitch_pct)
                    d = 16'sd0;                              // R1 zero is non-negative
                step(1'b1, d);
                ph = (ph + 1 == p) ? 0 : ph + 1;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (2) @(negedge clk);

        // R8 reset, R4 free-running length 7.
        do_reset();
        lock_en = 1'b0; min_count = 16'd7;
        run_wave(20, 120, 0, 10, 0);

        // R4 zero minimum read as 1.
        do_reset();
        min_count = 16'd0;
        run_wave(16, 60, 0, 0, 0);

        // R5, R2, R3 locked intervals with glitches.
        do_reset();
        lock_en = 1'b1; min_count = 16'd50;
        run_wave(20, 400, 40, 5, 0);

        // R6 no line: constant positive reference, then line returns.
        do_reset();
        lock_en = 1'b1; min_count = 16'd30;
        run_wave(20, 200, 0, 0, 1);
        run_wave(24, 300, 0, 0, 0);

        // R1 only rising changes: long cycle, single crossing each way.
        do_reset();
        lock_en = 1'b1; min_count = 16'd10;
        run_wave(90, 400, 0, 0, 0);

        // Random segments.
        for (int s = 0; s < 24; s++) begin
            do_reset();
            lock_en   = 1'($urandom % 2);
            min_count = CW'(1 + ($urandom % 150));
            run_wave(12 + ($urandom % 60), 400 + ($urandom % 200),
                     $urandom % 50, $urandom % 20, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule